// File: doc/BRIEF.md
# ADC Block Buffer with DMA Request

This block sits between a clocked pipeline ADC and a host processor. On every conversion clock pulse it stores the parallel ADC word in an internal FIFO. The host does not service each sample on its own. Instead, the block raises a request line once a full block of samples has gathered. A DMA engine on the host side then drains that block through an asynchronous memory-style read port, which has an active-low chip enable, an active-low read strobe and a data bus.

The ADC and the host port share one system clock. The host strobes are asynchronous to that clock, so they pass through a synchronizer before use. A word is consumed when the read strobe is released. The ADC keeps streaming while the host drains, so a capture and a pop can fall in the same cycle. The block flags samples lost to a full FIFO and reads made from an empty one. Both flags are sticky.

Top module: `adc_block_buffer`

## Requirements
- R1: After reset, `fill_level` is 0, `dma_req`, `ovf_flag` and `unf_flag` are 0, and `host_dout` reads 0.
- R2: On each rising clock edge where `conv_tick` is 1 and a slot is free, `adc_data` is stored and `fill_level` grows by one. `fill_level` never exceeds FIFO_DEPTH.
- R3: `host_dout` shows the oldest stored word, so words leave in arrival order. A completed read is a rising edge of `host_rd_n` while `host_ce_n` is 0. It removes exactly one word on the third rising clock edge after the strobe's release.
- R4: When `dma_req` is low and `fill_level` is at least BLOCK_WORDS, `dma_req` rises on the next clock edge.
- R5: `dma_req` falls on the edge that applies the BLOCK_WORDS-th word removed since it rose. If `fill_level` is still at least BLOCK_WORDS, it rises again one edge later.
- R6: A sample arriving while the FIFO is full, with no removal in that cycle, is dropped: the level and the stored words are unchanged. `ovf_flag` is set and stays set.
- R7: A completed read while the FIFO is empty leaves `fill_level` at 0. `host_dout` keeps the last word removed (0 after reset), and `unf_flag` is set and stays set.
- R8: A one-cycle pulse on `flag_clr` clears both `ovf_flag` and `unf_flag` on the next edge.
- R9: When the FIFO is full and a capture and a removal apply on the same edge, both take effect. The level stays at FIFO_DEPTH, the new word joins the tail, and `ovf_flag` is not set.
- R10: When the FIFO is empty and a capture and a completed read apply on the same edge, the read counts as an underflow and the sample is stored. The level becomes 1.
- R11: Strobes on `host_rd_n` while `host_ce_n` is 1 remove nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by the ADC and host sides |
| rst | input | 1 | Synchronous active-high reset |
| conv_tick | input | 1 | One-cycle pulse per conversion; qualifies `adc_data` |
| adc_data | input | DATA_W | Parallel ADC sample |
| host_ce_n | input | 1 | Host chip enable, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| flag_clr | input | 1 | Clears the sticky overflow and underflow flags |
| host_dout | output | DATA_W | Oldest stored word, or the last removed word when empty |
| fill_level | output | $clog2(FIFO_DEPTH+1) | Number of stored words |
| dma_req | output | 1 | Block-ready request to the DMA engine |
| ovf_flag | output | 1 | Sticky: a sample was dropped on a full FIFO |
| unf_flag | output | 1 | Sticky: a read hit an empty FIFO |

## Verification
Capture and removal meet on one edge in two places: at a full FIFO, where a careless design drops the sample and reports overflow, and at an empty one, where it might return the incoming word or skip the underflow. The bench knows that a removal applies on the third edge after the strobe's release. It places a `conv_tick` pulse on exactly that edge, first with the FIFO full and then with it empty. In the full case the level must stay at depth, the overflow flag must stay clear, and a full drain must return the new sample last. In the empty case the underflow flag must rise, the level must be 1, and the next read must return the new sample.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;

    // Per-cycle outcome of the storage array, decided from push/pop requests
    typedef struct packed {
        logic push_ok;     // sample written
        logic push_drop;   // sample lost on full storage
        logic pop_ok;      // word removed
        logic pop_empty;   // read met an empty store
    } fifo_evt_t;

    typedef enum logic [0:0] {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_t;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic rd_n,
    output logic done
);
    // Index STAGES-1 is the last synchronizer flop; index STAGES is an edge register
    logic [STAGES:0] rd_q;
    logic [STAGES:0] ce_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '1;
            ce_q <= '1;
        end else begin
            rd_q <= {rd_q[STAGES-1:0], rd_n};
            ce_q <= {ce_q[STAGES-1:0], ce_n};
        end
    end

    // Release of an enabled strobe
    assign done = rd_q[STAGES-1] & ~rd_q[STAGES] & ~ce_q[STAGES];
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
    import adcbuf_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [LW-1:0]     level,
    output fifo_evt_t         evt
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic [DATA_W-1:0] hold;
    logic              empty;

    assign empty = (level == '0);

    always_comb begin
        evt.pop_ok    = pop & ~empty;
        evt.pop_empty = pop & empty;
        evt.push_ok   = push & ((level != FULL_LVL) | evt.pop_ok);
        evt.push_drop = push & ~evt.push_ok;
    end

    always_ff @(posedge clk) begin
        if (evt.push_ok) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            hold  <= '0;
        end else begin
            if (evt.push_ok) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
            if (evt.pop_ok) begin
                rp   <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
                hold <= mem[rp];
            end
            level <= level + LW'(evt.push_ok) - LW'(evt.pop_ok);
        end
    end

    assign rdata = empty ? hold : mem[rp];
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
    import adcbuf_pkg::*;
#(
    parameter int BLOCK = 16,
    parameter int LW    = 6,
    localparam int CW   = $clog2(BLOCK)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] level,
    input  logic          pop_ok,
    output logic          req
);
    localparam logic [LW-1:0] BLK_LVL  = LW'(BLOCK);
    localparam logic [CW-1:0] LAST_CNT = CW'(BLOCK - 1);

    req_state_t    state;
    logic [CW-1:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= REQ_IDLE;
            rd_cnt <= '0;
        end else begin
            unique case (state)
                REQ_IDLE: begin
                    rd_cnt <= '0;
                    if (level >= BLK_LVL) state <= REQ_ACTIVE;
                end
                REQ_ACTIVE: begin
                    if (pop_ok) begin
                        if (rd_cnt == LAST_CNT) begin
                            state  <= REQ_IDLE;
                            rd_cnt <= '0;
                        end else begin
                            rd_cnt <= rd_cnt + 1'b1;
                        end
                    end
                end
                default: state <= REQ_IDLE;
            endcase
        end
    end

    assign req = (state == REQ_ACTIVE);
endmodule

// File: rtl/adc_block_buffer.sv
module adc_block_buffer
    import adcbuf_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int BLOCK_WORDS = 16,
    parameter int FIFO_DEPTH  = 2 * BLOCK_WORDS,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_tick,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              host_ce_n,
    input  logic              host_rd_n,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] host_dout,
    output logic [LVL_W-1:0]  fill_level,
    output logic              dma_req,
    output logic              ovf_flag,
    output logic              unf_flag
);
    // Block size must be a power of two in 8..256; storage at least two blocks
    localparam bit CFG_OK = is_pow2(BLOCK_WORDS) && (BLOCK_WORDS >= 8) &&
                            (BLOCK_WORDS <= 256) && (FIFO_DEPTH >= 2 * BLOCK_WORDS);

    logic      pop_strobe;
    fifo_evt_t evt;

    generate
        if (!CFG_OK) begin : g_bad_cfg
            $error("adc_block_buffer: illegal block size or depth");
        end
    endgenerate

    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .ce_n (host_ce_n),
        .rd_n (host_rd_n),
        .done (pop_strobe)
    );

    sample_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (conv_tick),
        .wdata (adc_data),
        .pop   (pop_strobe),
        .rdata (host_dout),
        .level (fill_level),
        .evt   (evt)
    );

    dma_req_ctrl #(.BLOCK(BLOCK_WORDS), .LW(LVL_W)) u_req (
        .clk    (clk),
        .rst    (rst),
        .level  (fill_level),
        .pop_ok (evt.pop_ok),
        .req    (dma_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            ovf_flag <= evt.push_drop | (ovf_flag & ~flag_clr);
            unf_flag <= evt.pop_empty | (unf_flag & ~flag_clr);
        end
    end
endmodule

// File: rtl/adc_block_buffer_chk.sv
module adc_block_buffer_chk #(
    parameter int DEPTH = 32,
    parameter int BLOCK = 16,
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             conv_tick,
    input logic             flag_clr,
    input logic [LVL_W-1:0] level,
    input logic             pop_evt,
    input logic             dma_req,
    input logic             ovf_flag,
    input logic             unf_flag
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] BLK_LVL  = LVL_W'(BLOCK);

    a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    a_r4_req_needs_block: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req) |-> $past(level) >= BLK_LVL);

    a_r6_drop_on_full: assert property (@(posedge clk) disable iff (rst)
        (level == FULL_LVL && conv_tick && !pop_evt) |=> (ovf_flag && level == FULL_LVL));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    a_r7_unf_on_empty: assert property (@(posedge clk) disable iff (rst)
        (pop_evt && level == '0) |=> unf_flag);

    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        (unf_flag && !flag_clr) |=> unf_flag);

    a_r9_full_both: assert property (@(posedge clk) disable iff (rst)
        (level == FULL_LVL && conv_tick && pop_evt) |=> level == FULL_LVL);
endmodule

bind adc_block_buffer adc_block_buffer_chk #(
    .DEPTH (FIFO_DEPTH),
    .BLOCK (BLOCK_WORDS),
    .LVL_W (LVL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_tick (conv_tick),
    .flag_clr  (flag_clr),
    .level     (fill_level),
    .pop_evt   (pop_strobe),
    .dma_req   (dma_req),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
);

// File: tb/tb_adc_block_buffer.sv
module tb_adc_block_buffer;
    localparam int DW    = 12;
    localparam int BLK   = 16;
    localparam int DEPTH = 32;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_tick = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          host_ce_n = 1'b1;
    logic          host_rd_n = 1'b1;
    logic          flag_clr = 1'b0;
    logic [DW-1:0] host_dout;
    logic [LW-1:0] fill_level;
    logic          dma_req, ovf_flag, unf_flag;

    int checks = 0;
    int errors = 0;
    int q[$];
    int last_word = 0;
    int seq = 1;

    always #5 clk = ~clk;

    adc_block_buffer #(.DATA_W(DW), .BLOCK_WORDS(BLK), .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .conv_tick(conv_tick), .adc_data(adc_data),
        .host_ce_n(host_ce_n), .host_rd_n(host_rd_n), .flag_clr(flag_clr),
        .host_dout(host_dout), .fill_level(fill_level), .dma_req(dma_req),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int next_sample();
        int v = seq & 12'hFFF;
        seq = seq + 7;
        return v;
    endfunction

    // R2: n consecutive conversion pulses; model drops on full storage (R6)
    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            conv_tick = 1'b1;
            adc_data  = DW'(next_sample());
            if (q.size() < DEPTH) q.push_back(int'(adc_data));
        end
        @(negedge clk);
        conv_tick = 1'b0;
    endtask

    // R3: one host read; removal lands on the third edge after release.
    // With tick_at_pop a sample is captured on that same edge (R9, R10).
    task automatic read_one(input bit tick_at_pop, input string tag);
        int exp_dout;
        @(negedge clk);
        host_ce_n = 1'b0;
        host_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_dout = (q.size() > 0) ? q[0] : last_word;
        chk({tag, " read data"}, int'(host_dout), exp_dout);
        host_rd_n = 1'b1;               // N0
        @(negedge clk);                 // N1
        @(negedge clk);                 // N2
        if (tick_at_pop) begin
            conv_tick = 1'b1;
            adc_data  = DW'(next_sample());
        end
        @(negedge clk);                 // N3: removal applied at P3
        if (q.size() > 0) last_word = q.pop_front();
        if (tick_at_pop) begin
            if (q.size() < DEPTH) q.push_back(int'(adc_data));
            conv_tick = 1'b0;
        end
        host_ce_n = 1'b1;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 level", int'(fill_level), 0);
        chk("R1 dma_req", int'(dma_req), 0);
        chk("R1 ovf", int'(ovf_flag), 0);
        chk("R1 unf", int'(unf_flag), 0);
        chk("R1 dout", int'(host_dout), 0);
    endtask

    task automatic t_order_and_enable();
        push_n(5);
        chk("R2 level after 5", int'(fill_level), 5);
        chk("R4 no request below block", int'(dma_req), 0);
        read_one(1'b0, "R3 first");
        chk("R3 level after one read", int'(fill_level), 4);
        read_one(1'b0, "R3 second");
        chk("R3 level after two reads", int'(fill_level), 3);
        // R11: strobes with chip enable high
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); host_rd_n = 1'b0;
            repeat (2) @(negedge clk); host_rd_n = 1'b1;
        end
        repeat (5) @(negedge clk);
        chk("R11 level unchanged", int'(fill_level), 3);
        chk("R11 dout unchanged", int'(host_dout), q[0]);
    endtask

    task automatic t_block_request();
        push_n(BLK - 3);
        chk("R2 level at block", int'(fill_level), BLK);
        chk("R4 request not yet", int'(dma_req), 0);
        @(negedge clk);
        chk("R4 request raised", int'(dma_req), 1);
        for (int i = 0; i < BLK - 1; i++) read_one(1'b0, "R5 drain");
        chk("R5 request held before last", int'(dma_req), 1);
        read_one(1'b0, "R5 last");
        chk("R5 request dropped", int'(dma_req), 0);
        chk("R5 level empty", int'(fill_level), 0);
        @(negedge clk);
        chk("R5 stays low when empty", int'(dma_req), 0);
    endtask

    task automatic t_overflow();
        push_n(DEPTH + 3);
        chk("R6 level capped", int'(fill_level), DEPTH);
        chk("R6 ovf set", int'(ovf_flag), 1);
        @(negedge clk);
        for (int i = 0; i < BLK; i++) read_one(1'b0, "R6 drain");
        chk("R5 dropped after block", int'(dma_req), 0);
        chk("R6 ovf sticky", int'(ovf_flag), 1);
        @(negedge clk);
        chk("R5 re-raised with block left", int'(dma_req), 1);
        pulse_clear();
        chk("R8 ovf cleared", int'(ovf_flag), 0);
    endtask

    task automatic t_full_coincident();
        push_n(DEPTH - int'(fill_level));
        chk("R9 precondition full", int'(fill_level), DEPTH);
        read_one(1'b1, "R9 read");
        @(negedge clk);
        chk("R9 level stays full", int'(fill_level), DEPTH);
        chk("R9 no overflow", int'(ovf_flag), 0);
        for (int i = 0; i < DEPTH; i++) read_one(1'b0, "R9 order");
        chk("R9 drained", int'(fill_level), 0);
    endtask

    task automatic t_underflow();
        read_one(1'b0, "R7 empty");
        chk("R7 level stays 0", int'(fill_level), 0);
        chk("R7 unf set", int'(unf_flag), 1);
        pulse_clear();
        chk("R8 unf cleared", int'(unf_flag), 0);
        read_one(1'b1, "R10 empty read");
        @(negedge clk);
        chk("R10 unf set", int'(unf_flag), 1);
        chk("R10 sample kept", int'(fill_level), 1);
        read_one(1'b0, "R10 new sample");
        chk("R10 drained", int'(fill_level), 0);
    endtask

    initial begin
        t_reset();
        t_order_and_enable();
        t_block_request();
        t_overflow();
        t_full_coincident();
        t_underflow();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule